// File: doc/BRIEF.md
# Store Queue with Broadcast Capture

This block holds stores that have been dispatched but not yet written to data memory. A slot is claimed when a store is dispatched. At that time the store carries either its data value or the tag of the unit that will produce the data. The effective address arrives later, when the store issues, through a separate fill port that names the slot. While a slot still waits on a producer tag, it watches the result broadcast bus. When the broadcast tag equals its own tag, the slot takes the broadcast value and marks its data as present.

Stores leave in the order they were claimed. Only the oldest slot may present a write to memory, and only once it holds both an address and its data. The write request is held until memory acknowledges it, and the acknowledge frees the slot. Tag value 0 means "data already present", so a store whose data was known at dispatch never waits on the bus. The depth must be a power of two and at least 2.

Top module: `sq_store_queue`

## Requirements
- R1: After reset the queue is empty: `full_o` is 0, `mem_req_o` is 0 and `alloc_idx_o` is 0.
- R2: `alloc_idx_o` shows the slot index that the next accepted allocation takes. It advances by one, modulo DEPTH, after each accepted allocation, and it is the index the fill port uses to supply that store's address.
- R3: A slot allocated with tag 0 and then given an address makes `mem_req_o` high one cycle after the fill, with `mem_addr_o` equal to the filled address and `mem_data_o` equal to the allocated data.
- R4: A slot allocated with a nonzero tag never requests a write while it waits. A broadcast with `bc_valid_i` high and a matching tag loads `bc_data_i` into the slot, and if the address is present the request rises in the next cycle carrying that value.
- R5: A broadcast whose tag differs from the slot's tag, a broadcast with `bc_valid_i` low, and a broadcast carrying tag 0 all leave a slot unchanged.
- R6: All waiting slots whose tags match one broadcast capture its value in the same cycle.
- R7: Writes leave strictly in allocation order. A younger slot that is ready does not request while the oldest slot still lacks its address or data.
- R8: A raised request keeps `mem_addr_o` and `mem_data_o` stable until `mem_ack_i`. The acknowledge frees the oldest slot, and the next slot is presented in the following cycle.
- R9: `full_o` is high exactly when DEPTH slots are occupied. An allocation attempted while full is refused: no slot is created and `alloc_idx_o` does not move.
- R10: A broadcast in the same cycle as an allocation whose nonzero tag matches it is captured by the newly allocated slot.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| alloc_valid_i | input | 1 | Claim a slot for a dispatched store |
| alloc_tag_i | input | TW | Producer tag of the store data, 0 if the data is present |
| alloc_data_i | input | DW | Store data, used when the tag is 0 |
| alloc_idx_o | output | log2(DEPTH) | Slot index the next allocation receives |
| full_o | output | 1 | All slots occupied |
| fill_valid_i | input | 1 | Write an effective address into a slot |
| fill_idx_i | input | log2(DEPTH) | Slot receiving the address |
| fill_addr_i | input | AW | Effective address |
| bc_valid_i | input | 1 | Result broadcast valid |
| bc_tag_i | input | TW | Tag of the broadcast result |
| bc_data_i | input | DW | Broadcast result value |
| mem_req_o | output | 1 | Write request for the oldest slot |
| mem_addr_o | output | AW | Write address |
| mem_data_o | output | DW | Write data |
| mem_ack_i | input | 1 | Memory accepted the write |

## Verification
Two pairs of functions can fall in one cycle. In the first, a slot is being claimed in the same cycle that the broadcast it depends on goes by. The bench drives the allocation and a matching broadcast on the same edge, and judges by the data of the write that later leaves. In the second, one broadcast hits several waiting slots at once, and the bench judges this from the two writes that drain back to back with the same value. A queue held full while a further allocation is attempted is judged by counting that exactly DEPTH writes drain afterwards, in claim order.

// File: rtl/sq_pkg.sv
package sq_pkg;
    // Per-slot command from the pointer control
    typedef struct packed {
        logic take;   // slot is claimed by a new store
        logic fill;   // slot receives its effective address
        logic free;   // slot is released after memory acknowledge
    } slot_cmd_t;
endpackage

// File: rtl/sq_slot.sv
module sq_slot #(
    parameter int AW = 16,
    parameter int DW = 16,
    parameter int TW = 3
) (
    input  logic                clk,
    input  logic                rst_n,
    input  sq_pkg::slot_cmd_t   cmd_i,
    input  logic [TW-1:0]       alloc_tag_i,
    input  logic [DW-1:0]       alloc_data_i,
    input  logic [AW-1:0]       fill_addr_i,
    input  logic                bc_valid_i,
    input  logic [TW-1:0]       bc_tag_i,
    input  logic [DW-1:0]       bc_data_i,
    output logic                ready_o,
    output logic [AW-1:0]       addr_o,
    output logic [DW-1:0]       data_o
);
    typedef struct packed {
        logic          busy;
        logic          avld;
        logic [TW-1:0] tag;
        logic [AW-1:0] addr;
        logic [DW-1:0] data;
    } slot_t;

    slot_t s_q, s_d;

    always_comb begin
        s_d = s_q;
        if (cmd_i.free) begin
            s_d.busy = 1'b0;
            s_d.avld = 1'b0;
        end
        // capture a broadcast while waiting on a producer
        if (s_q.busy && (s_q.tag != '0) && bc_valid_i && (bc_tag_i == s_q.tag)) begin
            s_d.tag  = '0;
            s_d.data = bc_data_i;
        end
        if (cmd_i.fill && s_q.busy) begin
            s_d.avld = 1'b1;
            s_d.addr = fill_addr_i;
        end
        if (cmd_i.take) begin
            s_d.busy = 1'b1;
            s_d.avld = 1'b0;
            s_d.tag  = alloc_tag_i;
            s_d.data = alloc_data_i;
            // producer result passing on the bus in the claim cycle
            if ((alloc_tag_i != '0) && bc_valid_i && (bc_tag_i == alloc_tag_i)) begin
                s_d.tag  = '0;
                s_d.data = bc_data_i;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

    assign ready_o = s_q.busy && s_q.avld && (s_q.tag == '0);
    assign addr_o  = s_q.addr;
    assign data_o  = s_q.data;
endmodule

// File: rtl/sq_ctrl.sv
module sq_ctrl #(
    parameter int DEPTH = 4,
    localparam int IW = $clog2(DEPTH),
    localparam int CW = IW + 1
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               alloc_valid_i,
    input  logic               fill_valid_i,
    input  logic [IW-1:0]      fill_idx_i,
    input  logic               ack_i,
    input  logic               head_ready_i,
    output sq_pkg::slot_cmd_t  cmd_o [DEPTH],
    output logic               full_o,
    output logic [IW-1:0]      tail_o,
    output logic [IW-1:0]      head_o,
    output logic               req_o
);
    typedef struct packed {
        logic [IW-1:0] head;
        logic [IW-1:0] tail;
        logic [CW-1:0] count;
    } ptr_t;

    ptr_t p_q, p_d;
    logic take, pop;

    assign full_o = (p_q.count == CW'(DEPTH));
    assign take   = alloc_valid_i && !full_o;
    assign req_o  = head_ready_i;
    assign pop    = head_ready_i && ack_i;

    always_comb begin
        p_d = p_q;
        if (take) p_d.tail = p_q.tail + IW'(1);
        if (pop)  p_d.head = p_q.head + IW'(1);
        p_d.count = p_q.count + CW'(take) - CW'(pop);
    end

    always_ff @(posedge clk) begin
        if (!rst_n) p_q <= '0;
        else        p_q <= p_d;
    end

    for (genvar i = 0; i < DEPTH; i++) begin : g_cmd
        assign cmd_o[i].take = take && (p_q.tail == IW'(i));
        assign cmd_o[i].fill = fill_valid_i && (fill_idx_i == IW'(i));
        assign cmd_o[i].free = pop && (p_q.head == IW'(i));
    end

    assign tail_o = p_q.tail;
    assign head_o = p_q.head;
endmodule

// File: rtl/sq_store_queue.sv
module sq_store_queue #(
    parameter int DEPTH = 4,
    parameter int AW    = 16,
    parameter int DW    = 16,
    parameter int TW    = 3,
    localparam int IW   = $clog2(DEPTH)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          alloc_valid_i,
    input  logic [TW-1:0] alloc_tag_i,
    input  logic [DW-1:0] alloc_data_i,
    output logic [IW-1:0] alloc_idx_o,
    output logic          full_o,
    input  logic          fill_valid_i,
    input  logic [IW-1:0] fill_idx_i,
    input  logic [AW-1:0] fill_addr_i,
    input  logic          bc_valid_i,
    input  logic [TW-1:0] bc_tag_i,
    input  logic [DW-1:0] bc_data_i,
    output logic          mem_req_o,
    output logic [AW-1:0] mem_addr_o,
    output logic [DW-1:0] mem_data_o,
    input  logic          mem_ack_i
);
    sq_pkg::slot_cmd_t cmd [DEPTH];
    logic              slot_ready [DEPTH];
    logic [AW-1:0]     slot_addr  [DEPTH];
    logic [DW-1:0]     slot_data  [DEPTH];
    logic [IW-1:0]     head_idx;

    sq_ctrl #(.DEPTH(DEPTH)) u_ctrl (
        .clk          (clk),
        .rst_n        (rst_n),
        .alloc_valid_i(alloc_valid_i),
        .fill_valid_i (fill_valid_i),
        .fill_idx_i   (fill_idx_i),
        .ack_i        (mem_ack_i),
        .head_ready_i (slot_ready[head_idx]),
        .cmd_o        (cmd),
        .full_o       (full_o),
        .tail_o       (alloc_idx_o),
        .head_o       (head_idx),
        .req_o        (mem_req_o)
    );

    for (genvar i = 0; i < DEPTH; i++) begin : g_slot
        sq_slot #(.AW(AW), .DW(DW), .TW(TW)) u_slot (
            .clk         (clk),
            .rst_n       (rst_n),
            .cmd_i       (cmd[i]),
            .alloc_tag_i (alloc_tag_i),
            .alloc_data_i(alloc_data_i),
            .fill_addr_i (fill_addr_i),
            .bc_valid_i  (bc_valid_i),
            .bc_tag_i    (bc_tag_i),
            .bc_data_i   (bc_data_i),
            .ready_o     (slot_ready[i]),
            .addr_o      (slot_addr[i]),
            .data_o      (slot_data[i])
        );
    end

    assign mem_addr_o = slot_addr[head_idx];
    assign mem_data_o = slot_data[head_idx];
endmodule

// File: rtl/sq_store_queue_chk.sv
module sq_store_queue_chk #(
    parameter int DEPTH = 4,
    parameter int AW    = 16,
    parameter int DW    = 16,
    localparam int IW   = $clog2(DEPTH),
    localparam int CW   = IW + 1
) (
    input logic          clk,
    input logic          rst_n,
    input logic          alloc_valid_i,
    input logic [IW-1:0] alloc_idx_o,
    input logic          full_o,
    input logic          mem_req_o,
    input logic [AW-1:0] mem_addr_o,
    input logic [DW-1:0] mem_data_o,
    input logic          mem_ack_i
);
    logic [CW-1:0] occ_q;

    always_ff @(posedge clk) begin
        if (!rst_n) occ_q <= '0;
        else occ_q <= occ_q + CW'(alloc_valid_i && !full_o) - CW'(mem_req_o && mem_ack_i);
    end

    // R9
    full_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
        full_o == (occ_q == CW'(DEPTH)));

    // R9
    full_refuse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (full_o && alloc_valid_i) |=> $stable(alloc_idx_o));

    // R2
    alloc_adv_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (alloc_valid_i && !full_o) |=> (alloc_idx_o == $past(alloc_idx_o) + IW'(1)));

    // R3
    req_nonempty_chk: assert property (@(posedge clk) disable iff (!rst_n)
        mem_req_o |-> (occ_q != '0));

    // R8
    req_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req_o && !mem_ack_i) |=> (mem_req_o && $stable(mem_addr_o) && $stable(mem_data_o)));
endmodule

bind sq_store_queue sq_store_queue_chk #(.DEPTH(DEPTH), .AW(AW), .DW(DW)) u_chk (.*);

// File: tb/sq_store_queue_bench.sv
module sq_store_queue_bench;
    localparam int DEPTH = 4;
    localparam int AW = 16;
    localparam int DW = 16;
    localparam int TW = 3;
    localparam int IW = $clog2(DEPTH);

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic alloc_valid_i = 1'b0;
    logic [TW-1:0] alloc_tag_i = '0;
    logic [DW-1:0] alloc_data_i = '0;
    logic [IW-1:0] alloc_idx_o;
    logic full_o;
    logic fill_valid_i = 1'b0;
    logic [IW-1:0] fill_idx_i = '0;
    logic [AW-1:0] fill_addr_i = '0;
    logic bc_valid_i = 1'b0;
    logic [TW-1:0] bc_tag_i = '0;
    logic [DW-1:0] bc_data_i = '0;
    logic mem_req_o;
    logic [AW-1:0] mem_addr_o;
    logic [DW-1:0] mem_data_o;
    logic mem_ack_i = 1'b0;

    always #5 clk = ~clk;

    sq_store_queue #(.DEPTH(DEPTH), .AW(AW), .DW(DW), .TW(TW)) u_sq_store_queue (.*);

    int n_chk = 0;
    int n_bad = 0;
    bit done = 1'b0;
    logic [IW-1:0] exp_idx = '0;

    typedef struct packed {
        logic [TW-1:0] tag;
        logic [DW-1:0] data;
        logic [AW-1:0] addr;
        logic          bv;
        logic [TW-1:0] btag;
        logic [DW-1:0] bdata;
        logic          ereq;
        logic [DW-1:0] edata;
    } vec_t;

    localparam vec_t VECS [6] = '{
        '{3'd0, 16'h1111, 16'h3000, 1'b0, 3'd0, 16'h0000, 1'b1, 16'h1111}, // R3
        '{3'd4, 16'hDEAD, 16'h3008, 1'b1, 3'd4, 16'h008F, 1'b1, 16'h008F}, // R4
        '{3'd2, 16'h0000, 16'h3010, 1'b1, 3'd5, 16'h7777, 1'b0, 16'h0000}, // R5 other tag
        '{3'd7, 16'h0000, 16'h3018, 1'b0, 3'd7, 16'h4444, 1'b0, 16'h0000}, // R5 valid low
        '{3'd1, 16'h0000, 16'h0000, 1'b1, 3'd1, 16'hFFFF, 1'b1, 16'hFFFF}, // R4
        '{3'd0, 16'h2222, 16'hFFFF, 1'b1, 3'd0, 16'h9999, 1'b1, 16'h2222}  // R5 tag 0
    };

    task automatic tick();
        @(posedge clk);
        #1;
    endtask

    task automatic chk(input bit ok, input string r, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s act=%0h exp=%0h", r, act, exp);
        end
    endtask

    task automatic alloc(input logic [TW-1:0] t, input logic [DW-1:0] d, output logic [IW-1:0] idx);
        chk(alloc_idx_o == exp_idx, "R2 index", 32'(alloc_idx_o), 32'(exp_idx));
        idx = alloc_idx_o;
        alloc_valid_i = 1'b1; alloc_tag_i = t; alloc_data_i = d;
        tick();
        alloc_valid_i = 1'b0;
        exp_idx = exp_idx + IW'(1);
    endtask

    task automatic fill(input logic [IW-1:0] idx, input logic [AW-1:0] a);
        fill_valid_i = 1'b1; fill_idx_i = idx; fill_addr_i = a;
        tick();
        fill_valid_i = 1'b0;
    endtask

    task automatic bcast(input logic [TW-1:0] t, input logic [DW-1:0] d);
        bc_valid_i = 1'b1; bc_tag_i = t; bc_data_i = d;
        tick();
        bc_valid_i = 1'b0;
    endtask

    task automatic ack();
        mem_ack_i = 1'b1;
        tick();
        mem_ack_i = 1'b0;
    endtask

    task automatic finish_run();
        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            n_chk++; n_bad++;
            $display("FAIL watchdog act=0 exp=1");
            finish_run();
        end
    end

    initial begin
        logic [IW-1:0] ia, ib;
        logic [IW-1:0] ids [DEPTH];
        repeat (3) tick();
        rst_n = 1'b1;
        tick();
        // R1
        chk(full_o == 1'b0, "R1 full", 32'(full_o), 0);
        chk(mem_req_o == 1'b0, "R1 req", 32'(mem_req_o), 0);
        chk(alloc_idx_o == '0, "R1 index", 32'(alloc_idx_o), 0);

        for (int v = 0; v < 6; v++) begin
            alloc(VECS[v].tag, VECS[v].data, ia);
            fill(ia, VECS[v].addr);
            if (VECS[v].tag != '0)
                chk(mem_req_o == 1'b0, "R4 waits", 32'(mem_req_o), 0);
            bc_valid_i = VECS[v].bv; bc_tag_i = VECS[v].btag; bc_data_i = VECS[v].bdata;
            tick();
            bc_valid_i = 1'b0;
            chk(mem_req_o == VECS[v].ereq, "R5 req", 32'(mem_req_o), 32'(VECS[v].ereq));
            if (VECS[v].ereq) begin
                chk(mem_data_o == VECS[v].edata, "R3 data", 32'(mem_data_o), 32'(VECS[v].edata));
                chk(mem_addr_o == VECS[v].addr, "R3 addr", 32'(mem_addr_o), 32'(VECS[v].addr));
            end else begin
                bcast(VECS[v].tag, 16'h5A5A);
                chk(mem_req_o && mem_data_o == 16'h5A5A, "R4 capture", 32'(mem_data_o), 32'h5A5A);
            end
            ack();
            chk(mem_req_o == 1'b0, "R8 freed", 32'(mem_req_o), 0);
        end

        // R7: younger ready slot waits behind older waiting slot
        alloc(3'd3, 16'h0000, ia);
        alloc(3'd0, 16'h000B, ib);
        fill(ia, 16'h0100);
        fill(ib, 16'h0200);
        chk(mem_req_o == 1'b0, "R7 order", 32'(mem_req_o), 0);
        bcast(3'd3, 16'h000A);
        chk(mem_req_o && mem_data_o == 16'h000A, "R7 head data", 32'(mem_data_o), 32'h000A);
        chk(mem_addr_o == 16'h0100, "R7 head addr", 32'(mem_addr_o), 32'h0100);
        // R8: hold without acknowledge
        tick(); tick();
        chk(mem_req_o && mem_data_o == 16'h000A && mem_addr_o == 16'h0100, "R8 hold",
            32'(mem_data_o), 32'h000A);
        ack();
        chk(mem_req_o && mem_data_o == 16'h000B, "R8 next data", 32'(mem_data_o), 32'h000B);
        chk(mem_addr_o == 16'h0200, "R8 next addr", 32'(mem_addr_o), 32'h0200);
        ack();
        chk(mem_req_o == 1'b0, "R8 drained", 32'(mem_req_o), 0);

        // R6: one broadcast feeds two slots
        alloc(3'd5, 16'h0000, ia);
        alloc(3'd5, 16'h0001, ib);
        fill(ia, 16'h0300);
        fill(ib, 16'h0308);
        bcast(3'd5, 16'h1234);
        chk(mem_req_o && mem_data_o == 16'h1234, "R6 first", 32'(mem_data_o), 32'h1234);
        ack();
        chk(mem_req_o && mem_data_o == 16'h1234, "R6 second", 32'(mem_data_o), 32'h1234);
        chk(mem_addr_o == 16'h0308, "R6 second addr", 32'(mem_addr_o), 32'h0308);
        ack();

        // R10: broadcast in the claim cycle
        bc_valid_i = 1'b1; bc_tag_i = 3'd6; bc_data_i = 16'h0066;
        alloc(3'd6, 16'h0000, ia);
        bc_valid_i = 1'b0;
        fill(ia, 16'h0400);
        chk(mem_req_o && mem_data_o == 16'h0066, "R10 capture", 32'(mem_data_o), 32'h0066);
        ack();

        // R9: fill the queue, try one more, then drain
        for (int k = 0; k < DEPTH; k++) begin
            logic [IW-1:0] t;
            alloc(3'd0, DW'(16'h00C0 + k), t);
            ids[k] = t;
        end
        chk(full_o == 1'b1, "R9 full", 32'(full_o), 1);
        chk(mem_req_o == 1'b0, "R9 no addr", 32'(mem_req_o), 0);
        alloc_valid_i = 1'b1; alloc_tag_i = 3'd0; alloc_data_i = 16'hEEEE;
        tick();
        alloc_valid_i = 1'b0;
        chk(alloc_idx_o == exp_idx, "R9 refused index", 32'(alloc_idx_o), 32'(exp_idx));
        chk(full_o == 1'b1, "R9 still full", 32'(full_o), 1);
        for (int k = 0; k < DEPTH; k++) fill(ids[k], AW'(16'h0500 + 8 * k));
        for (int k = 0; k < DEPTH; k++) begin
            chk(mem_req_o && mem_data_o == DW'(16'h00C0 + k), "R9 drain data",
                32'(mem_data_o), 32'(16'h00C0 + k));
            chk(mem_addr_o == AW'(16'h0500 + 8 * k), "R9 drain addr",
                32'(mem_addr_o), 32'(16'h0500 + 8 * k));
            ack();
        end
        chk(mem_req_o == 1'b0, "R9 only DEPTH writes", 32'(mem_req_o), 0);
        chk(full_o == 1'b0, "R9 empty", 32'(full_o), 0);
        chk(alloc_idx_o == exp_idx, "R2 after drain", 32'(alloc_idx_o), 32'(exp_idx));

        finish_run();
    end
endmodule